// File: doc/BRIEF.md
# Multi-Cycle Stored-Program Byte Processor

This block is a small 8-bit processor. Its program and its data share one 256-byte memory, which it reaches through a single byte-wide port. The core holds sixteen 8-bit working registers. It runs a fetch, decode and execute loop over 16-bit instructions. The top nibble of each instruction selects the operation. The remaining twelve bits are read as three 4-bit fields: a register index, or a register index followed by an 8-bit address or immediate byte.

The memory behind the port is expected to return read data one cycle after the address is presented. A fetch therefore reads two consecutive bytes over three cycles. The byte at the lower address supplies the opcode nibble. After the fetch the program counter has moved on by two. Reset clears the registers and loads the program counter from a start-address input. A halt instruction stops the core until the next reset, and the core raises a halted flag while it is stopped.

Top module: `sp_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, all registers read as 00, halted is low, and mem_addr equals start_addr. After reset, a store of any register that has not been written since reset writes 00.
- R2: A fetch puts the program counter (PC) on mem_addr, then PC+1 for two cycles. The byte from PC is the high byte of the instruction, and its bits 7:4 are the opcode. PC advances by 2 modulo 256, so a program can run across the FF to 00 boundary.
- R3: Opcode 1 (1RXY) loads register R from memory cell XY. mem_addr shows XY in the execute cycle and the byte is written one cycle later. Opcode 2 (2RXY) loads register R with the byte XY.
- R4: Opcode 3 (3RXY) raises mem_we for exactly one cycle, with mem_addr = XY and mem_wdata = register R.
- R5: Opcode 5 (5RST) writes S + T modulo 256 into register R. Opcode 4 (40RS) copies register R into register S.
- R6: Opcodes 7, 8 and 9 (xRST) write S OR T, S AND T and S XOR T into register R.
- R7: Opcode A (AR0X) rotates register R right by X modulo 8. Bits leaving bit 0 re-enter at bit 7.
- R8: Opcode B (BRXY) sets PC to XY when register R equals register 0, and otherwise falls through. With R = 0 the jump is always taken.
- R9: Opcode C raises halted. halted then stays high until reset, mem_we stays low and mem_addr holds still.
- R10: Opcodes 0, 6, D, E and F change no register and no memory cell, and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 8 | Program counter value loaded during reset |
| mem_addr | output | 8 | Memory address for reads and writes |
| mem_wdata | output | 8 | Byte to be written to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Byte read from memory, one cycle after its address |
| halted | output | 1 | High while the core is stopped |

## Verification
The registers cannot be observed directly, so each scenario ends its program with stores that copy the registers of interest into spare memory cells. The bench then reads those cells from its own memory model. The hardest cases to reach from the ports are the conditional jump falling through and the rotate count wrapping modulo 8. The jump program places a store on each possible path, so a wrong branch leaves a distinctive pattern of cells. The rotate case uses a count of 9 and expects the same result as a count of 1. Running across the top of memory is reached by starting execution at FE.

// File: rtl/spc_pkg.sv
package spc_pkg;

   typedef enum logic [3:0] {
      OPC_LDM = 4'h1,
      OPC_LDI = 4'h2,
      OPC_STM = 4'h3,
      OPC_MOV = 4'h4,
      OPC_ADD = 4'h5,
      OPC_IOR = 4'h7,
      OPC_AND = 4'h8,
      OPC_XOR = 4'h9,
      OPC_ROR = 4'hA,
      OPC_JEQ = 4'hB,
      OPC_HLT = 4'hC
   } opcode_t;

   typedef enum logic [2:0] {
      PH_FA,
      PH_FB,
      PH_FC,
      PH_EXE,
      PH_LDW,
      PH_STOP
   } phase_t;

   typedef enum logic [2:0] {
      FN_PASS,
      FN_ADD,
      FN_IOR,
      FN_AND,
      FN_XOR,
      FN_ROR
   } alu_fn_t;

endpackage

// File: rtl/spc_regfile.sv
module spc_regfile #(
   parameter int NREG = 16,
   parameter int DW   = 8,
   parameter int NRD  = 4,
   localparam int RW  = $clog2(NREG)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    we,
   input  logic [RW-1:0]           waddr,
   input  logic [DW-1:0]           wdata,
   input  logic [NRD-1:0][RW-1:0]  raddr,
   output logic [NRD-1:0][DW-1:0]  rdata
);

   logic [DW-1:0] cells [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) cells[i] <= '0;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = cells[raddr[g]];
   end

endmodule

// File: rtl/spc_alu.sv
module spc_alu
   import spc_pkg::*;
#(
   parameter int DW         = 8,
   parameter int CW         = 4,
   parameter bit ROT_STAGED = 1'b1,
   localparam int SW        = $clog2(DW)
) (
   input  alu_fn_t         fn,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic [CW-1:0]   amt,
   output logic [DW-1:0]   y
);

   logic [DW-1:0] rot;

   if (ROT_STAGED) begin : g_rot_log
      logic [DW-1:0] stg [SW+1];
      assign stg[0] = a;
      for (genvar g = 0; g < SW; g++) begin : g_stage
         assign stg[g+1] = amt[g] ? {stg[g][(2**g)-1:0], stg[g][DW-1:(2**g)]}
                                  : stg[g];
      end
      assign rot = stg[SW];
   end else begin : g_rot_dbl
      logic [2*DW-1:0] dbl;
      assign dbl = {a, a} >> amt[SW-1:0];
      assign rot = dbl[DW-1:0];
   end

   always_comb begin
      unique case (fn)
         FN_ADD:  y = a + b;
         FN_IOR:  y = a | b;
         FN_AND:  y = a & b;
         FN_XOR:  y = a ^ b;
         FN_ROR:  y = rot;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
   import spc_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 8,
   parameter int FW = 4,
   localparam int IW = 2*DW
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [AW-1:0]  start_addr,
   input  logic [DW-1:0]  mem_rdata,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_we,
   output logic [DW-1:0]  mem_wdata,
   output logic           halted,
   output logic [FW-1:0]  fld_r,
   output logic [FW-1:0]  fld_s,
   output logic [FW-1:0]  fld_t,
   output alu_fn_t        alu_fn,
   output logic           a_from_r,
   input  logic [DW-1:0]  rd_r,
   input  logic [DW-1:0]  rd_zero,
   input  logic [DW-1:0]  alu_y,
   output logic           rf_we,
   output logic [FW-1:0]  rf_waddr,
   output logic [DW-1:0]  rf_wdata,
   output phase_t         phase,
   output logic [AW-1:0]  pc
);

   logic [IW-1:0] ir_q;
   logic [AW-1:0] pc_q;
   phase_t        ph_q;
   logic [3:0]    opc;
   logic [DW-1:0] xy;
   logic          is_alu;

   assign opc   = ir_q[IW-1:IW-4];
   assign fld_r = ir_q[3*FW-1:2*FW];
   assign fld_s = ir_q[2*FW-1:FW];
   assign fld_t = ir_q[FW-1:0];
   assign xy    = ir_q[2*FW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= start_addr;
         ph_q <= PH_FA;
         ir_q <= '0;
      end else begin
         unique case (ph_q)
            PH_FA: ph_q <= PH_FB;
            PH_FB: begin
               ir_q[IW-1:DW] <= mem_rdata;
               ph_q          <= PH_FC;
            end
            PH_FC: begin
               ir_q[DW-1:0] <= mem_rdata;
               pc_q         <= pc_q + AW'(2);
               ph_q         <= PH_EXE;
            end
            PH_EXE: begin
               if (opc == OPC_LDM)      ph_q <= PH_LDW;
               else if (opc == OPC_HLT) ph_q <= PH_STOP;
               else                     ph_q <= PH_FA;
               if (opc == OPC_JEQ && rd_r == rd_zero) pc_q <= AW'(xy);
            end
            PH_LDW:  ph_q <= PH_FA;
            default: ph_q <= PH_STOP;
         endcase
      end
   end

   always_comb begin
      mem_addr = pc_q;
      if (ph_q == PH_FB || ph_q == PH_FC) mem_addr = pc_q + AW'(1);
      else if (ph_q == PH_EXE && (opc == OPC_LDM || opc == OPC_STM)) mem_addr = AW'(xy);
   end

   assign mem_we    = (ph_q == PH_EXE) && (opc == OPC_STM);
   assign mem_wdata = rd_r;
   assign halted    = (ph_q == PH_STOP);
   assign phase     = ph_q;
   assign pc        = pc_q;

   always_comb begin
      is_alu   = 1'b1;
      a_from_r = 1'b0;
      unique case (opc)
         OPC_MOV: alu_fn = FN_PASS;
         OPC_ADD: alu_fn = FN_ADD;
         OPC_IOR: alu_fn = FN_IOR;
         OPC_AND: alu_fn = FN_AND;
         OPC_XOR: alu_fn = FN_XOR;
         OPC_ROR: begin
            alu_fn   = FN_ROR;
            a_from_r = 1'b1;
         end
         default: begin
            alu_fn = FN_PASS;
            is_alu = 1'b0;
         end
      endcase
   end

   always_comb begin
      rf_we    = (ph_q == PH_LDW) ||
                 ((ph_q == PH_EXE) && (is_alu || opc == OPC_LDI));
      rf_waddr = (opc == OPC_MOV) ? fld_t : fld_r;
      if (ph_q == PH_LDW)      rf_wdata = mem_rdata;
      else if (opc == OPC_LDI) rf_wdata = xy;
      else                     rf_wdata = alu_y;
   end

endmodule

// File: rtl/sp_core.sv
module sp_core
   import spc_pkg::*;
#(
   parameter int DW         = 8,
   parameter int AW         = 8,
   parameter int NREG       = 16,
   parameter bit ROT_STAGED = 1'b1,
   localparam int FW        = $clog2(NREG),
   localparam int NRD       = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [AW-1:0]  start_addr,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   output logic           mem_we,
   input  logic [DW-1:0]  mem_rdata,
   output logic           halted
);

   if (AW != DW) begin : g_bad_aw
      $error("sp_core: address width must equal data width");
   end
   if (4 + 3*FW != 2*DW) begin : g_bad_fmt
      $error("sp_core: opcode plus three fields must fill two bytes");
   end
   if ((1 << FW) != NREG) begin : g_bad_nreg
      $error("sp_core: register count must be a power of two");
   end

   logic [FW-1:0]            fld_r, fld_s, fld_t;
   logic [NRD-1:0][FW-1:0]   raddr;
   logic [NRD-1:0][DW-1:0]   rdata;
   alu_fn_t                  alu_fn;
   logic                     a_from_r;
   logic [DW-1:0]            alu_a, alu_y;
   logic                     rf_we;
   logic [FW-1:0]            rf_waddr;
   logic [DW-1:0]            rf_wdata;
   phase_t                   phase_w;
   logic [AW-1:0]            pc_w;

   assign raddr[0] = fld_r;
   assign raddr[1] = fld_s;
   assign raddr[2] = fld_t;
   assign raddr[3] = '0;
   assign alu_a    = a_from_r ? rdata[0] : rdata[1];

   spc_ctrl #(.DW(DW), .AW(AW), .FW(FW)) u_ctrl (
      .clk(clk), .rst(rst), .start_addr(start_addr), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .halted(halted),
      .fld_r(fld_r), .fld_s(fld_s), .fld_t(fld_t), .alu_fn(alu_fn), .a_from_r(a_from_r),
      .rd_r(rdata[0]), .rd_zero(rdata[3]), .alu_y(alu_y),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .phase(phase_w), .pc(pc_w)
   );

   spc_regfile #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_rf (
      .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .raddr(raddr), .rdata(rdata)
   );

   spc_alu #(.DW(DW), .CW(FW), .ROT_STAGED(ROT_STAGED)) u_alu (
      .fn(alu_fn), .a(alu_a), .b(rdata[2]), .amt(fld_t), .y(alu_y)
   );

endmodule

// File: rtl/sp_core_chk.sv
module sp_core_chk
   import spc_pkg::*;
#(
   parameter int AW = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           halted,
   input logic           mem_we,
   input logic [AW-1:0]  mem_addr,
   input logic [AW-1:0]  pc,
   input phase_t         phase
);

   p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
      phase == PH_FC |=> pc == AW'($past(pc) + AW'(2)));

   p_store_once_r4: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   p_no_store_halted_r9: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   p_pc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(pc) && $stable(mem_addr)));

endmodule

bind sp_core sp_core_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst(rst), .halted(halted), .mem_we(mem_we),
   .mem_addr(mem_addr), .pc(pc_w), .phase(phase_w)
);

// File: tb/tb_sp_core.sv
module tb_sp_core;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] start_addr = '0;
   logic [7:0] mem_addr, mem_wdata, mem_rdata;
   logic       mem_we, halted;

   logic       clr = 1'b0, ld_en = 1'b0;
   logic [7:0] ld_addr = '0, ld_data = '0;
   logic [7:0] mem [256];
   int         wr_cnt;
   int         n_chk = 0, n_bad = 0;
   logic [7:0] pa;

   always #5 clk = ~clk;

   sp_core dut (
      .clk(clk), .rst(rst), .start_addr(start_addr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
   );

   always @(posedge clk) begin
      if (clr) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
         wr_cnt <= 0;
      end else if (ld_en) begin
         mem[ld_addr] <= ld_data;
      end else if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      mem_rdata <= mem[mem_addr];
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic emit(input logic [15:0] w);
      poke(pa, w[15:8]);
      poke(pa + 8'd1, w[7:0]);
      pa = pa + 8'd2;
   endtask

   task automatic setup(input logic [7:0] base);
      @(negedge clk);
      rst = 1'b1;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      pa  = base;
   endtask

   task automatic boot(input logic [7:0] s);
      @(negedge clk);
      rst = 1'b1; start_addr = s;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
   endtask

   task automatic run(input string req);
      int k = 0;
      while (!halted && k < 400) begin
         @(negedge clk);
         k++;
      end
      check({req, " halted"}, int'(halted), 1);
   endtask

   task automatic t_fetch_and_load;
      setup(8'hA0);
      emit(16'h156C); emit(16'h166D); emit(16'h5056); emit(16'h306E); emit(16'hC000);
      poke(8'h6C, 8'h12); poke(8'h6D, 8'h34);
      boot(8'hA0);
      check("R1 first fetch address", mem_addr, 8'hA0);
      check("R1 halted low after reset", halted, 0);
      @(negedge clk); check("R2 second byte address", mem_addr, 8'hA1);
      @(negedge clk); check("R2 second byte held", mem_addr, 8'hA1);
      @(negedge clk); check("R3 load address in execute", mem_addr, 8'h6C);
      @(negedge clk); @(negedge clk);
      check("R2 next fetch at start+2", mem_addr, 8'hA2);
      run("R9");
      check("R3 R5 loaded sum stored", mem[8'h6E], 8'h46);
   endtask

   task automatic t_imm_store;
      setup(8'h50);
      emit(16'h2ABC); emit(16'h2F01); emit(16'h3AE0); emit(16'h3FE1); emit(16'hC000);
      boot(8'h50);
      run("R4");
      check("R3 R4 immediate BC stored", mem[8'hE0], 8'hBC);
      check("R3 R4 immediate 01 stored", mem[8'hE1], 8'h01);
      check("R4 one write per store", wr_cnt, 2);
   endtask

   task automatic t_alu;
      setup(8'h40);
      emit(16'h2165); emit(16'h22F0); emit(16'h5412); emit(16'h7512);
      emit(16'h8612); emit(16'h9712); emit(16'h2A7F); emit(16'h2B01);
      emit(16'h5CAB); emit(16'h4018); emit(16'hA101); emit(16'h2365);
      emit(16'hA304); emit(16'h2965); emit(16'hA909);
      emit(16'h3490); emit(16'h3591); emit(16'h3692); emit(16'h3793);
      emit(16'h3C94); emit(16'h3895); emit(16'h3196); emit(16'h3397);
      emit(16'h3998); emit(16'hC000);
      boot(8'h40);
      run("R6");
      check("R5 add wraps 65+F0", mem[8'h90], 8'h55);
      check("R6 or", mem[8'h91], 8'hF5);
      check("R6 and", mem[8'h92], 8'h60);
      check("R6 xor", mem[8'h93], 8'h95);
      check("R5 add 7F+01", mem[8'h94], 8'h80);
      check("R5 move copies source", mem[8'h95], 8'h65);
      check("R7 rotate by 1", mem[8'h96], 8'hB2);
      check("R7 rotate by 4", mem[8'h97], 8'h56);
      check("R7 rotate count 9 acts as 1", mem[8'h98], 8'hB2);
   endtask

   task automatic t_jump;
      setup(8'h20);
      emit(16'h2107); emit(16'h2007); emit(16'hB130); emit(16'h2299); emit(16'hC000);
      pa = 8'h30;
      emit(16'h2355); emit(16'hB240); emit(16'h3380); emit(16'h3281);
      emit(16'hB03C); emit(16'hC000); emit(16'h2466); emit(16'h3482); emit(16'hC000);
      boot(8'h20);
      run("R8");
      check("R8 taken jump reached target", mem[8'h80], 8'h55);
      check("R8 skipped load left r2 clear", mem[8'h81], 8'h00);
      check("R8 jump on register 0 always taken", mem[8'h82], 8'h66);
   endtask

   task automatic t_halt;
      setup(8'h10);
      emit(16'h2177); emit(16'hC000); emit(16'h3140);
      boot(8'h10);
      run("R9");
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check("R9 no write after halt", mem_we, 0);
         check("R9 address frozen", mem_addr, 8'h14);
         check("R9 stays halted", halted, 1);
      end
      check("R9 following store not executed", mem[8'h40], 8'h00);
   endtask

   task automatic t_unsupported;
      setup(8'h00);
      emit(16'h2133); emit(16'h0123); emit(16'h6145); emit(16'hD1FF);
      emit(16'hE1FF); emit(16'hF1FF); emit(16'h3170); emit(16'hC000);
      boot(8'h00);
      run("R10");
      check("R10 register kept across no-ops", mem[8'h70], 8'h33);
      check("R10 no extra writes", wr_cnt, 1);
      check("R10 cell FF untouched", mem[8'hFF], 8'h00);
   endtask

   task automatic t_reset_clears;
      setup(8'h00);
      emit(16'h25AA); emit(16'hC000);
      boot(8'h00);
      run("R1");
      setup(8'h00);
      emit(16'h3560); emit(16'hC000);
      poke(8'h60, 8'hFF);
      boot(8'h00);
      check("R1 halted cleared by reset", halted, 0);
      run("R1");
      check("R1 register cleared by reset", mem[8'h60], 8'h00);
   endtask

   task automatic t_wrap;
      setup(8'hFE);
      emit(16'h2142); emit(16'h3150); emit(16'hC000);
      boot(8'hFE);
      run("R2");
      check("R2 program runs across FF to 00", mem[8'h50], 8'h42);
   endtask

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_fetch_and_load;
      t_imm_store;
      t_alu;
      t_jump;
      t_halt;
      t_unsupported;
      t_reset_clears;
      t_wrap;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule